// File: doc/BRIEF.md
# Atomic 64-bit Compare-and-Swap Unit

This unit performs one atomic 64-bit compare-and-exchange on a single 8-byte memory word. The caller supplies an expected value and a replacement value, each as a high and a low 32-bit half, together with a word address, the current status flags and an option that requests bus locking. On a start pulse the unit issues a read of the word and compares the returned data with the expected value. It then always issues a write to the same word.

When the data matches the expected value, the unit writes the replacement value and sets the zero flag. When the data differs, the unit writes the data it just read back unchanged, clears the zero flag, and places the old data on its expected-value register outputs. The caller can then retry with that data.

Whatever the outcome, a read is never left without its write. When locking is requested, the lock line is held high from the read request until the write is acknowledged. With single-cycle acknowledges the operation completes in a fixed number of clocks.

Top module: `cas64_unit`

## Requirements
- R1: The expected value is {exp_hi, exp_lo} and the replacement value is {new_hi, new_lo}, where the high input forms bits 63:32 and the low input forms bits 31:0. The result outputs use the same split.
- R2: If the memory word equals the expected value, the replacement value is written to the word and flag bit ZF_BIT (bit 6) of flags_out becomes 1.
- R3: If the memory word differs in any bit, flag bit 6 becomes 0, the word keeps its old contents, and {res_hi, res_lo} take the old word.
- R4: Every operation issues exactly one read, followed by exactly one write to the same address, whether or not the compare succeeds.
- R5: With lock_en high at start, mem_lock is high continuously from the cycle the read is requested until the write is acknowledged, and it is low afterwards. With lock_en low, mem_lock never rises. A locked read is always followed by a locked write.
- R6: All flags_out bits other than bit 6 take the flags_in value sampled at start. flags_out changes only in the cycle that done rises.
- R7: When every acknowledge arrives in the cycle after the request, done rises exactly 10 cycles after the clock edge that accepts start. done stays high for exactly one cycle, and busy is high from the accepting edge through the done cycle.
- R8: A start pulse while busy is high is ignored: it causes no extra bus cycle and no extra done pulse.
- R9: On a match, res_hi and res_lo keep their previous values.
- R10: After a synchronous reset, busy, done, mem_req and mem_lock are low, and flags_out, res_hi and res_lo are zero.
- R11: If each acknowledge is delayed by up to two extra cycles, done still rises exactly 10 cycles after start, and the lock window grows to cover the later write acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| lock_en | input | 1 | Request a locked read/write pair |
| addr_in | input | ADDR_W | Byte address of the 8-byte word |
| exp_hi | input | 32 | Expected value, bits 63:32 |
| exp_lo | input | 32 | Expected value, bits 31:0 |
| new_hi | input | 32 | Replacement value, bits 63:32 |
| new_lo | input | 32 | Replacement value, bits 31:0 |
| flags_in | input | FLAG_W | Current status flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flags_out | output | FLAG_W | Status flags with updated zero flag |
| res_hi | output | 32 | Expected-value register, bits 63:32 |
| res_lo | output | 32 | Expected-value register, bits 31:0 |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write enable |
| mem_lock | output | 1 | Bus lock |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | 64 | Bus write data |
| mem_rdata | input | 64 | Bus read data |
| mem_ack | input | 1 | Bus acknowledge |

## Verification
The compare is tried with an exact match, with a mismatch confined to the high half, and with a mismatch confined to the low half. These cases show whether both halves take part in the compare and whether each sits in the right bit range. Runs with locking on and off, with a delayed acknowledge, and with a start pulse repeated while busy separate the lock window, the fixed latency and the start filtering from the data path. Flag inputs with bit 6 both set and clear, and back-to-back match and mismatch operations, show that only the zero flag moves and that the result registers update only on a failed compare.

// File: rtl/cas64_pkg.sv
package cas64_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CMP, ST_WRITE, ST_WAIT, ST_DONE
  } cas_state_t;
endpackage

// File: rtl/cas64_ctrl.sv
module cas64_ctrl
  import cas64_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic lock_en,
  input  logic ack,
  output logic busy,
  output logic done,
  output logic req,
  output logic we,
  output logic lock,
  output logic cap,
  output logic rd_take,
  output logic cmp_en,
  output logic fin
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  cas_state_t state_q;
  logic [CNT_W-1:0] cnt_q;
  logic lock_q;

  assign cap     = (state_q == ST_IDLE) && start;
  assign rd_take = (state_q == ST_READ) && ack;
  assign cmp_en  = (state_q == ST_CMP);
  assign fin     = (state_q == ST_WAIT) && (cnt_q >= CNT_W'(LATENCY - 1));

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);
  assign req  = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign we   = (state_q == ST_WRITE);
  assign lock = lock_q && ((state_q == ST_READ) || (state_q == ST_CMP) ||
                           (state_q == ST_WRITE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && cnt_q != CNT_W'(LATENCY)) cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_READ;
          cnt_q   <= '0;
          lock_q  <= lock_en;
        end
        ST_READ:  if (ack) state_q <= ST_CMP;
        ST_CMP:   state_q <= ST_WRITE;
        ST_WRITE: if (ack) state_q <= ST_WAIT;
        ST_WAIT:  if (fin) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) |-> $past(we && ack));
  // R4
  write_follows_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_en |=> (req && we));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && start) |=> busy);
endmodule

// File: rtl/cas64_datapath.sv
module cas64_datapath #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32,
  parameter int FLAG_W = 8,
  parameter int ZF_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              rd_take,
  input  logic              cmp_en,
  input  logic              fin,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [HALF_W-1:0] exp_hi,
  input  logic [HALF_W-1:0] exp_lo,
  input  logic [HALF_W-1:0] new_hi,
  input  logic [HALF_W-1:0] new_lo,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [2*HALF_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2*HALF_W-1:0] wdata_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [HALF_W-1:0] res_hi_o,
  output logic [HALF_W-1:0] res_lo_o
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [FLAG_W-1:0] ZMASK = FLAG_W'(1) << ZF_BIT;

  logic [WORD_W-1:0] exp_q, new_q, rd_q;
  logic [FLAG_W-1:0] flg_q;
  logic              match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q    <= '0;
      new_q    <= '0;
      rd_q     <= '0;
      flg_q    <= '0;
      match_q  <= 1'b0;
      addr_o   <= '0;
      wdata_o  <= '0;
      flags_o  <= '0;
      res_hi_o <= '0;
      res_lo_o <= '0;
    end else begin
      if (cap) begin
        exp_q  <= {exp_hi, exp_lo};
        new_q  <= {new_hi, new_lo};
        flg_q  <= flags_in;
        addr_o <= addr_in;
      end
      if (rd_take) rd_q <= rdata;
      if (cmp_en) begin
        match_q <= (rd_q == exp_q);
        wdata_o <= (rd_q == exp_q) ? new_q : rd_q;
      end
      if (fin) begin
        flags_o <= (flg_q & ~ZMASK) | (match_q ? ZMASK : '0);
        if (!match_q) {res_hi_o, res_lo_o} <= rd_q;
      end
    end
  end

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ({res_hi_o, res_lo_o} != $past({res_hi_o, res_lo_o})) |-> $past(fin && !match_q));
  // R6
  flags_when_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_o != $past(flags_o)) |-> $past(fin));
  // R6
  flags_other_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> (((flags_o ^ $past(flg_q)) & ~ZMASK) == '0));
endmodule

// File: rtl/cas64_unit.sv
module cas64_unit #(
  parameter int ADDR_W  = 32,
  parameter int FLAG_W  = 8,
  parameter int ZF_BIT  = 6,
  parameter int LATENCY = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              lock_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [31:0]       exp_hi,
  input  logic [31:0]       exp_lo,
  input  logic [31:0]       new_hi,
  input  logic [31:0]       new_lo,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              busy,
  output logic              done,
  output logic [FLAG_W-1:0] flags_out,
  output logic [31:0]       res_hi,
  output logic [31:0]       res_lo,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack
);
  logic cap, rd_take, cmp_en, fin;

  cas64_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .lock_en(lock_en), .ack(mem_ack),
    .busy(busy), .done(done), .req(mem_req), .we(mem_we), .lock(mem_lock),
    .cap(cap), .rd_take(rd_take), .cmp_en(cmp_en), .fin(fin)
  );

  cas64_datapath #(.ADDR_W(ADDR_W), .HALF_W(32), .FLAG_W(FLAG_W), .ZF_BIT(ZF_BIT)) u_dp (
    .clk(clk), .rst(rst), .cap(cap), .rd_take(rd_take), .cmp_en(cmp_en), .fin(fin),
    .addr_in(addr_in), .exp_hi(exp_hi), .exp_lo(exp_lo), .new_hi(new_hi),
    .new_lo(new_lo), .flags_in(flags_in), .rdata(mem_rdata),
    .addr_o(mem_addr), .wdata_o(mem_wdata), .flags_o(flags_out),
    .res_hi_o(res_hi), .res_lo_o(res_lo)
  );
endmodule

// File: tb/test_cas64_unit.sv
module test_cas64_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ZF = 6;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, lock_en = 1'b0;
  logic [31:0] addr_in = '0, exp_hi = '0, exp_lo = '0, new_hi = '0, new_lo = '0;
  logic [7:0]  flags_in = '0, flags_out;
  logic        busy, done, mem_req, mem_we, mem_lock, mem_ack;
  logic [31:0] res_hi, res_lo, mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  int checks = 0, fails = 0, cyc = 0;
  int ack_delay = 0, wait_cnt = 0, rd_cnt = 0, wr_cnt = 0, wr_locked = 0;
  logic [63:0] mem [16];
  logic [63:0] res_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cas64_unit i_cas64_unit (
    .clk(clk), .rst(rst), .start(start), .lock_en(lock_en), .addr_in(addr_in),
    .exp_hi(exp_hi), .exp_lo(exp_lo), .new_hi(new_hi), .new_lo(new_lo),
    .flags_in(flags_in), .busy(busy), .done(done), .flags_out(flags_out),
    .res_hi(res_hi), .res_lo(res_lo), .mem_req(mem_req), .mem_we(mem_we),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // behavioural memory with programmable acknowledge delay
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_rdata <= '0; wait_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == ack_delay) begin
        mem_ack <= 1'b1; wait_cnt <= 0;
        if (mem_we) begin
          mem[mem_addr[6:3]] <= mem_wdata; wr_cnt <= wr_cnt + 1;
          if (mem_lock) wr_locked <= wr_locked + 1;
        end else begin
          mem_rdata <= mem[mem_addr[6:3]]; rd_cnt <= rd_cnt + 1;
        end
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: act=%0d exp<20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // run one operation and compare every cycle against the model
  task automatic run_op(input int idx, input logic [63:0] ev, input logic [63:0] nv,
                        input logic [7:0] fl, input bit lk, input int dly, input bit restart);
    logic [63:0] old = mem[idx];
    bit match = (old == ev);
    logic [63:0] mem_exp = match ? nv : old;
    logic [7:0] fl_exp = (fl & ~(8'h1 << ZF)) | (match ? (8'h1 << ZF) : 8'h0);
    int rd0 = rd_cnt, wr0 = wr_cnt, wl0 = wr_locked;
    logic [7:0] fl_prev = flags_out;
    ack_delay = dly;
    @(negedge clk);
    addr_in = 32'(idx * 8); {exp_hi, exp_lo} = ev; {new_hi, new_lo} = nv;
    flags_in = fl; lock_en = lk; start = 1'b1;
    for (int i = 0; i <= 12; i++) begin
      @(negedge clk);
      start = (restart && (i == 3 || i == 10)) ? 1'b1 : 1'b0;
      // R7 done timing and busy window; R11 with delayed acks
      chk(done == (i == 10), dly > 0 ? "R11 done" : "R7 done", 64'(done), 64'(i == 10));
      chk(busy == (i <= 10), "R7 busy", 64'(busy), 64'(i <= 10));
      // R5 lock window
      chk(mem_lock == (lk && i <= 4 + 2 * dly), "R5 lock", 64'(mem_lock), 64'(lk && i <= 4 + 2 * dly));
      if (i < 10) chk(flags_out == fl_prev, "R6 flags early", 64'(flags_out), 64'(fl_prev));
      if (i == 10) begin
        chk(flags_out[ZF] == match, match ? "R2 zf" : "R3 zf", 64'(flags_out[ZF]), 64'(match));
        chk(flags_out == fl_exp, "R6 flags", 64'(flags_out), 64'(fl_exp));
        if (!match) res_model = old;
        chk({res_hi, res_lo} == res_model, match ? "R9 res hold" : "R3 res", {res_hi, res_lo}, res_model);
        chk(res_hi == res_model[63:32], "R1 res_hi", 64'(res_hi), res_model[63:32]);
      end
    end
    chk(mem[idx] == mem_exp, match ? "R2 mem" : "R3 mem", mem[idx], mem_exp);
    chk(rd_cnt - rd0 == 1 && wr_cnt - wr0 == 1, restart ? "R8 one pair" : "R4 one pair",
        64'((rd_cnt - rd0) * 16 + (wr_cnt - wr0)), 64'h11);
    chk((wr_locked - wl0) == int'(lk), "R5 locked write", 64'(wr_locked - wl0), 64'(lk));
  endtask

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = {32'hA000_0000 + 32'(k), 32'h5000_0000 + 32'(k * 3)};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !mem_req && !mem_lock, "R10 ctrl", {busy, done, mem_req, mem_lock}, 0);
    chk(flags_out == 0 && res_hi == 0 && res_lo == 0, "R10 regs", {res_hi, res_lo}, 0);
    rst = 1'b0;
    // R2 match with lock
    run_op(2, mem[2], 64'h1111_2222_3333_4444, 8'h81, 1, 0, 0);
    // R3 R1 mismatch in high half only
    run_op(3, mem[3] ^ 64'h0000_0001_0000_0000, 64'hDEAD_BEEF_0000_0001, 8'hFF, 1, 0, 0);
    // R3 R1 mismatch in low half only
    run_op(4, mem[4] ^ 64'h0000_0000_8000_0000, 64'h1, 8'h40, 0, 0, 0);
    // R9 match after a mismatch keeps results
    run_op(5, mem[5], 64'hCAFE_F00D_1234_5678, 8'h3C, 0, 0, 0);
    // R11 delayed acknowledges
    run_op(6, mem[6], 64'h0F0F_0F0F_F0F0_F0F0, 8'h00, 1, 2, 0);
    run_op(7, 64'h0, 64'h0, 8'hBF, 1, 1, 0);
    // R8 start repeated while busy
    run_op(8, mem[8], 64'h7777_8888_9999_AAAA, 8'h10, 1, 0, 1);
    // second swap on an already swapped word
    run_op(2, 64'h1111_2222_3333_4444, 64'h5, 8'h02, 1, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule